// File: doc/BRIEF.md
# Per-Port Jabber Timer Controller

This block guards one transmitting port of a shared medium against a station that never stops sending. It watches a qualified activity signal for the port, which has already been squelched upstream, and measures how long each packet lasts. A packet that stays active for longer than the jabber limit trips the block. The port's traffic is then cut off from forwarding, a collision request is raised for that port alone after a short settling delay, and the test pulse that normally follows a transmission is inhibited.

The port recovers only after its line has been idle for one unbroken unjab period. Any activity seen during that period throws away the idle time counted so far, and the full period has to be counted again. A bypass input removes the whole function: the port stays enabled and no collision request is raised. Every time span is a parameter counted in clock cycles. The defaults match 13.5 ms of packet time, 0.5 s of idle time and about 500 ns of collision delay at 125 MHz. A bench can use short values.

All inputs and outputs are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `jabber_guard`

## Requirements
- R1: After reset the port is enabled (`port_en`=1). `coll_req`, `jab_flag` and `sqe_inhibit` are 0, and `tx_fwd` follows `tx_active`.
- R2: A packet with fewer than `JAB_LIMIT_CYC` consecutive clock samples of `tx_active`=1 leaves `port_en` at 1, and `tx_fwd` equals `tx_active` throughout.
- R3: On the clock edge that samples `tx_active`=1 for the `JAB_LIMIT_CYC`-th consecutive time, the port becomes jabbered. From that edge on, `port_en`=0, `tx_fwd`=0 and `jab_flag`=1.
- R4: `coll_req` rises exactly `COLL_DLY_CYC` clock edges after `port_en` falls. It stays high while the port is jabbered and is never high while `port_en`=1.
- R5: While the port is jabbered and `tx_active` stays 1, the port stays jabbered for any length of time.
- R6: On the edge that samples `tx_active`=0 for the `UNJAB_CYC`-th consecutive time in the jabbered state, the port is released. From that edge on, `port_en`=1 and `coll_req`, `jab_flag` and `sqe_inhibit` are all 0.
- R7: Any sample of `tx_active`=1 during the idle count restarts it. A further `UNJAB_CYC` consecutive idle samples are then needed for release.
- R8: `sqe_inhibit` is 1 exactly while the port is jabbered, that is, while `port_en`=0.
- R9: While `jab_bypass`=1, the port stays enabled with `coll_req`=0 whatever `tx_active` does. A jabbered port is released on the first edge that samples `jab_bypass`=1.
- R10: After a release, a new packet is timed from zero. It needs a full `JAB_LIMIT_CYC` consecutive active samples to trip the port again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Squelched transmit activity seen on the port |
| jab_bypass | input | 1 | 1 disables the jabber function |
| tx_fwd | output | 1 | Activity allowed onward (tx_active gated by the enable) |
| port_en | output | 1 | 1 while the port's transmit path is enabled |
| coll_req | output | 1 | Collision request for this port only |
| jab_flag | output | 1 | Jabber status for an indicator |
| sqe_inhibit | output | 1 | 1 suppresses the post-transmit test pulse |

## Verification
A packet timer that is off by one shows up at once. The `port_en` edge moves a cycle away from the `JAB_LIMIT_CYC`-th active sample, and the bench probes both the sample just before that boundary and the boundary sample itself. An idle timer that fails to restart on renewed activity releases the port one short burst too early, which shows at `port_en` on a known edge. A collision delay counter that is wrong moves the `coll_req` rise away from its exact offset after `port_en` falls. A stuck state shows at the next check as a mismatch between `port_en`, `jab_flag` and `sqe_inhibit`, or as a bypass that does not release the port within one edge.

// File: rtl/jbr_pkg.sv
package jbr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_TIMING     = 2'd1,
    ST_JAB_ACTIVE = 2'd2,
    ST_JAB_IDLE   = 2'd3
  } jbr_state_e;

  function automatic logic jbr_is_jabbered(input jbr_state_e s);
    return (s == ST_JAB_ACTIVE) || (s == ST_JAB_IDLE);
  endfunction

  function automatic int unsigned jbr_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/jbr_span_timer.sv
module jbr_span_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import jbr_pkg::*;

  localparam int unsigned W = jbr_cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // The count is the number of consecutive run samples before this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q == LAST);

  // R7: a gap in run always forces a fresh span
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (LIMIT > 1) && !run |=> !done);

endmodule

// File: rtl/jbr_fsm.sv
module jbr_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_active,
  input  logic               bypass,
  input  logic               pkt_done,
  input  logic               idle_done,
  output jbr_pkg::jbr_state_e state,
  output logic               jabbered
);
  import jbr_pkg::*;

  jbr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (bypass) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pkt_done)       state_d = ST_JAB_ACTIVE;
          else if (tx_active) state_d = ST_TIMING;
        end
        ST_TIMING: begin
          if (pkt_done)        state_d = ST_JAB_ACTIVE;
          else if (!tx_active) state_d = ST_IDLE;
        end
        ST_JAB_ACTIVE: begin
          if (!tx_active) state_d = idle_done ? ST_IDLE : ST_JAB_IDLE;
        end
        ST_JAB_IDLE: begin
          if (tx_active)      state_d = ST_JAB_ACTIVE;
          else if (idle_done) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign jabbered = jbr_is_jabbered(state_q);

  // R3: an expired packet timer trips the port on the next edge
  p_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !bypass |=> jabbered);

  // R5: ongoing activity keeps a jabbered port disabled
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    jabbered && tx_active && !bypass |=> jabbered);

  // R9: bypass clears the jabber state
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> !jabbered);

  // R6: release only through bypass or a completed idle span
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jabbered) |-> ($past(bypass) || $past(idle_done)));

endmodule

// File: rtl/jbr_coll_delay.sv
module jbr_coll_delay #(
  parameter int unsigned DELAY = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jabbered,
  output logic coll_req
);
  import jbr_pkg::*;

  localparam int unsigned W = jbr_cnt_width(DELAY);
  localparam logic [W-1:0] TARGET = W'(DELAY);

  logic [W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (!jabbered) begin
      dly_q <= '0;
    end else if (dly_q != TARGET) begin
      dly_q <= dly_q + 1'b1;
    end
  end

  assign coll_req = jabbered && (dly_q == TARGET);

  // R4: once raised, the request holds for the rest of the jabber episode
  p_coll_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coll_req && jabbered |=> coll_req || !jabbered);

  // R4: with a nonzero delay the request never rises with the disable
  p_coll_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (DELAY > 0) && $rose(coll_req) |-> $past(jabbered));

endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int unsigned JAB_LIMIT_CYC = 1_687_500,
  parameter int unsigned UNJAB_CYC     = 62_500_000,
  parameter int unsigned COLL_DLY_CYC  = 62
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic jab_bypass,
  output logic tx_fwd,
  output logic port_en,
  output logic coll_req,
  output logic jab_flag,
  output logic sqe_inhibit
);
  import jbr_pkg::*;

  jbr_state_e state;
  logic       jabbered;
  logic       pkt_run, pkt_done;
  logic       idle_run, idle_done;
  logic       coll_raw;

  assign pkt_run  = tx_active && !jabbered && !jab_bypass;
  assign idle_run = jabbered && !tx_active && !jab_bypass;

  jbr_span_timer #(.LIMIT(JAB_LIMIT_CYC)) u_pkt_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pkt_run),
    .done  (pkt_done)
  );

  jbr_span_timer #(.LIMIT(UNJAB_CYC)) u_idle_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (idle_run),
    .done  (idle_done)
  );

  jbr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .bypass    (jab_bypass),
    .pkt_done  (pkt_done),
    .idle_done (idle_done),
    .state     (state),
    .jabbered  (jabbered)
  );

  jbr_coll_delay #(.DELAY(COLL_DLY_CYC)) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .jabbered (jabbered),
    .coll_req (coll_raw)
  );

  assign port_en     = (state == ST_IDLE) || (state == ST_TIMING);
  assign tx_fwd      = tx_active && port_en;
  assign coll_req    = coll_raw;
  assign jab_flag    = jabbered;
  assign sqe_inhibit = !port_en;

  // R4: no collision request on an enabled port
  p_coll_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coll_req |-> !port_en);

  // R7: activity while jabbered means the idle span cannot end on the next edge
  p_idle_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (UNJAB_CYC > 1) && jabbered && tx_active |=> !idle_done);

  // R8: the test-pulse inhibit follows the jabber status
  p_sqe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_inhibit == jab_flag);

endmodule

// File: tb/jabber_guard_tb_top.sv
`timescale 1ns/1ps
module jabber_guard_tb_top;

  localparam int unsigned L = 20;
  localparam int unsigned U = 30;
  localparam int unsigned D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic jab_bypass = 1'b0;
  logic tx_fwd, port_en, coll_req, jab_flag, sqe_inhibit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  jabber_guard #(.JAB_LIMIT_CYC(L), .UNJAB_CYC(U), .COLL_DLY_CYC(D)) dut_i (
    .clk (clk), .rst_n (rst_n), .tx_active (tx_active), .jab_bypass (jab_bypass),
    .tx_fwd (tx_fwd), .port_en (port_en), .coll_req (coll_req),
    .jab_flag (jab_flag), .sqe_inhibit (sqe_inhibit)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_jabbered(input string req, input logic jab);
    check(req, "port_en", port_en, !jab);
    check(req, "jab_flag", jab_flag, jab);
    check(req, "sqe_inhibit", sqe_inhibit, jab);
  endtask

  task automatic t_reset();
    check("R1", "port_en", port_en, 1'b1);
    check("R1", "coll_req", coll_req, 1'b0);
    check("R1", "jab_flag", jab_flag, 1'b0);
    check("R1", "sqe_inhibit", sqe_inhibit, 1'b0);
    check("R1", "tx_fwd", tx_fwd, 1'b0);
  endtask

  task automatic t_short_packet();
    tx_active = 1'b1;
    wait_edges(L - 1);
    check("R2", "port_en", port_en, 1'b1);
    check("R2", "tx_fwd", tx_fwd, 1'b1);
    tx_active = 1'b0;
    wait_edges(1);
    check("R2", "port_en", port_en, 1'b1);
    check("R2", "tx_fwd", tx_fwd, 1'b0);
    wait_edges(2);
  endtask

  task automatic t_trip_and_hold();
    tx_active = 1'b1;
    wait_edges(L - 1);
    check("R3", "port_en before limit", port_en, 1'b1);
    wait_edges(1);
    check_jabbered("R3", 1'b1);
    check("R8", "sqe_inhibit", sqe_inhibit, 1'b1);
    check("R3", "tx_fwd", tx_fwd, 1'b0);
    check("R4", "coll_req at trip", coll_req, 1'b0);
    wait_edges(D - 1);
    check("R4", "coll_req before delay", coll_req, 1'b0);
    wait_edges(1);
    check("R4", "coll_req after delay", coll_req, 1'b1);
    wait_edges(2 * U);
    check_jabbered("R5", 1'b1);
    check("R5", "coll_req", coll_req, 1'b1);
  endtask

  task automatic t_unjab_restart();
    tx_active = 1'b0;
    wait_edges(U - 1);
    check_jabbered("R7", 1'b1);
    tx_active = 1'b1;
    wait_edges(1);
    check_jabbered("R7", 1'b1);
    tx_active = 1'b0;
    wait_edges(U - 1);
    check_jabbered("R7", 1'b1);
    check("R7", "coll_req", coll_req, 1'b1);
    wait_edges(1);
    check_jabbered("R6", 1'b0);
    check("R6", "coll_req", coll_req, 1'b0);
  endtask

  task automatic t_fresh_packet();
    tx_active = 1'b1;
    wait_edges(L - 1);
    check("R10", "port_en before limit", port_en, 1'b1);
    wait_edges(1);
    check("R10", "port_en at limit", port_en, 1'b0);
    tx_active = 1'b0;
    wait_edges(U);
    check_jabbered("R6", 1'b0);
    wait_edges(2);
  endtask

  task automatic t_bypass();
    jab_bypass = 1'b1;
    tx_active  = 1'b1;
    wait_edges(2 * L);
    check("R9", "port_en", port_en, 1'b1);
    check("R9", "coll_req", coll_req, 1'b0);
    check("R9", "tx_fwd", tx_fwd, 1'b1);
    tx_active  = 1'b0;
    jab_bypass = 1'b0;
    wait_edges(2);
    tx_active = 1'b1;
    wait_edges(L + D);
    check_jabbered("R9", 1'b1);
    check("R9", "coll_req before bypass", coll_req, 1'b1);
    jab_bypass = 1'b1;
    wait_edges(1);
    check_jabbered("R9", 1'b0);
    check("R9", "coll_req after bypass", coll_req, 1'b0);
    jab_bypass = 1'b0;
    tx_active  = 1'b0;
    wait_edges(2);
  endtask

  task automatic run_all();
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(1);
    t_reset();
    t_short_packet();
    t_trip_and_hold();
    t_unjab_restart();
    t_fresh_packet();
    t_bypass();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule